// File: doc/BRIEF.md
# Ordered-Key Watchdog Timer

This block is a watchdog timer with a small word-addressed register interface. Software arms it by setting an enable bit together with a 5-bit delay selector. The timeout period is a power of two chosen by that selector. A one-cycle `tick_i` strobe stands in for the slow counter clock. Software keeps the system alive by writing a fixed pair of key words, first to the arm register and then to the commit register. Any wrong value, or a commit write with no arm before it, counts as a fault and triggers a reset request at once.

The block keeps a three-bit code that says why the last reset happened. Software reads this code from the arm register after the system restarts. Only the power-on reset clears the code. The block's own reset request and the end of a reset pulse leave it unchanged. Clearing the enable bit does not stop a running counter on its own: the counter stops only after a complete valid key pair has been written.

The controller has four states, all in `wdk_fsm`:
- `ST_OFF`: counter idle.
- `ST_RUN`: counting, no key pending.
- `ST_ARMED`: counting, first key accepted.
- `ST_FIRE`: reset request active.

Its transitions are:
- Start: `ST_OFF` to `ST_RUN` while the enable bit is set; the counter is loaded.
- Arm: `ST_RUN` to `ST_ARMED` on a correct arm-key write.
- Service: `ST_ARMED` to `ST_RUN` on a correct commit-key write with enable set; the counter is reloaded.
- Stop: `ST_ARMED` to `ST_OFF` on a correct commit-key write with enable clear.
- Fault, timeout and soft reset: any of `ST_OFF`, `ST_RUN` or `ST_ARMED` to `ST_FIRE`. The fault and timeout paths apply only in `ST_RUN` and `ST_ARMED`.
- Release: `ST_FIRE` to `ST_OFF` after the pulse length; the configuration is cleared.
- User reset: any state to `ST_OFF`.

Top module: `wdk_top`

## Requirements
- R1: After power-on reset (`por_n` low), `rst_req_o` and `irq_o` are 0, the cause field reads 0 and the configuration register reads 0.
- R2: Register offsets are: soft reset 0x0, configuration 0x4, arm key 0x8, commit key 0xC. Configuration bit 31 is the enable bit and bits 4:0 are the delay selector D; a write to it reads back those fields with all other bits 0.
- R3: One cycle after the enable bit is set, the counter loads the period 2^(D+1). On the 2^(D+1)-th tick after that, the block enters `ST_FIRE` and records cause 1 (timeout); no earlier tick does this.
- R4: Writing 0xABCD1234 to offset 0x8 and then 0x4321DCBA to offset 0xC reloads the counter to the full period. Expiry then needs a further 2^(D+1) ticks.
- R5: A wrong value written to either key register while the counter runs causes an immediate reset request and records cause 2 (bad service).
- R6: A commit-key write that has no accepted arm-key write before it causes a reset request and records cause 2, even when its value is correct.
- R7: Clearing the enable bit while the counter runs leaves it counting, so it can still time out. The counter stops (`ST_OFF`) only when a valid key pair follows.
- R8: A write of any value to offset 0x0 causes a reset request and records cause 3 (soft reset).
- R9: A high `user_rst_i` at a clock edge records cause 4 (user reset), returns the block to `ST_OFF` and clears the configuration. It raises no reset request.
- R10: The cause field (arm-register read, bits 2:0) survives the block's own reset pulse. At the end of the pulse the configuration is cleared. Only `por_n` sets the cause field to 0.
- R11: While the counter is stopped, key writes and ticks have no effect: no reset request, and the cause field is unchanged.
- R12: A reset request lasts exactly 16 clock cycles. `irq_o` is high during the pulse only when the cause is a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| user_rst_i | input | 1 | Synchronous external user reset, active high |
| tick_i | input | 1 | Counter tick strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rst_req_o | output | 1 | System reset request, active high |
| irq_o | output | 1 | Level interrupt, high while a timeout reset is requested |

## Verification
The hardest situation to reach is a counter whose enable bit is already clear but which is still running and waiting for the key pair that stops it. The stimulus gets there by starting the timer and then rewriting the configuration with enable clear. One run then lets that counter time out, which shows the clear alone changed nothing. A second run writes a valid key pair and shows that no later tick can fire. Key writes that arrive while the counter is stopped are checked against the persisting cause code. This shows they are ignored rather than treated as faults.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_ARMED = 2'd2,
        ST_FIRE  = 2'd3
    } wdk_state_e;

    localparam logic [2:0] CAUSE_POWER   = 3'd0;
    localparam logic [2:0] CAUSE_TIMEOUT = 3'd1;
    localparam logic [2:0] CAUSE_TICKLE  = 3'd2;
    localparam logic [2:0] CAUSE_SOFT    = 3'd3;
    localparam logic [2:0] CAUSE_USER    = 3'd4;

    localparam int OFS_SOFT   = 'h0;
    localparam int OFS_CFG    = 'h4;
    localparam int OFS_ARM    = 'h8;
    localparam int OFS_COMMIT = 'hC;

    localparam logic [31:0] KEY_ARM    = 32'hABCD_1234;
    localparam logic [31:0] KEY_COMMIT = 32'h4321_DCBA;

    localparam int CFG_EN_BIT = 31;

endpackage

// File: rtl/wdk_cfg.sv
module wdk_cfg #(
    parameter int DATA_W  = 32,
    parameter int DELAY_W = 5,
    parameter int CNT_W   = (1 << DELAY_W) + 1
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               clr,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               en,
    output logic [DELAY_W-1:0] delay,
    output logic [CNT_W-1:0]   period
);
    import wdk_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en    <= 1'b0;
            delay <= '0;
        end else if (clr) begin
            en    <= 1'b0;
            delay <= '0;
        end else if (wr) begin
            en    <= wdata[CFG_EN_BIT];
            delay <= wdata[DELAY_W-1:0];
        end
    end

    always_comb begin
        period = ONE << (32'(delay) + 32'd1);
    end

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int CNT_W = 33
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= period;
        else if (run && tick && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    always_comb begin
        expire = run && tick && (cnt_q == CNT_W'(1));
    end

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        (!run && !load) |=> $stable(cnt_q)); // R11

    AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!por_n)
        load |=> (cnt_q == $past(period))); // R4

endmodule

// File: rtl/wdk_fsm.sv
module wdk_fsm #(
    parameter int PULSE_LEN = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       user_rst_i,
    input  logic       wr_soft,
    input  logic       wr_k1,
    input  logic       wr_k2,
    input  logic       k1_ok,
    input  logic       k2_ok,
    input  logic       cfg_en,
    input  logic       expire,
    output logic       run,
    output logic       load,
    output logic       cfg_clr,
    output logic       rst_req,
    output logic       irq,
    output logic [2:0] cause
);
    import wdk_pkg::*;

    localparam int PC_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_LEN - 1);

    wdk_state_e      state_q, state_d;
    logic [2:0]      cause_q, cause_d;
    logic [PC_W-1:0] pc_q, pc_d;

    // state, cause and pulse-count registers
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_OFF;
            cause_q <= CAUSE_POWER;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            pc_q    <= pc_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        load    = 1'b0;
        cfg_clr = 1'b0;
        pc_d    = (state_q == ST_FIRE) ? pc_q + PC_W'(1) : '0;
        if (user_rst_i) begin
            state_d = ST_OFF;
            cause_d = CAUSE_USER;
            cfg_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (wr_soft) begin
                        state_d = ST_FIRE;
                        cause_d = CAUSE_SOFT;
                    end else if (cfg_en) begin
                        state_d = ST_RUN;
                        load    = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (wr_soft) begin
                        state_d = ST_FIRE;
                        cause_d = CAUSE_SOFT;
                    end else if (wr_k2 || (wr_k1 && !k1_ok)) begin
                        state_d = ST_FIRE;
                        cause_d = CAUSE_TICKLE;
                    end else if (expire) begin
                        state_d = ST_FIRE;
                        cause_d = CAUSE_TIMEOUT;
                    end else if (wr_k1) begin
                        state_d = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (wr_soft) begin
                        state_d = ST_FIRE;
                        cause_d = CAUSE_SOFT;
                    end else if ((wr_k1 && !k1_ok) || (wr_k2 && !k2_ok)) begin
                        state_d = ST_FIRE;
                        cause_d = CAUSE_TICKLE;
                    end else if (expire) begin
                        state_d = ST_FIRE;
                        cause_d = CAUSE_TIMEOUT;
                    end else if (wr_k2) begin
                        load    = 1'b1;
                        state_d = cfg_en ? ST_RUN : ST_OFF;
                    end
                end
                ST_FIRE: begin
                    if (pc_q == PC_LAST) begin
                        state_d = ST_OFF;
                        cfg_clr = 1'b1;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        run     = (state_q == ST_RUN) || (state_q == ST_ARMED);
        rst_req = (state_q == ST_FIRE);
        irq     = (state_q == ST_FIRE) && (cause_q == CAUSE_TIMEOUT);
        cause   = cause_q;
    end

    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!por_n)
        cause_q <= CAUSE_USER); // R10

    AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(rst_req) && !user_rst_i) |=> rst_req); // R12

    AST_SOFT_FIRES: assert property (@(posedge clk) disable iff (!por_n)
        (wr_soft && !user_rst_i && !rst_req) |=> (rst_req && cause_q == CAUSE_SOFT)); // R8

    AST_USER_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        user_rst_i |=> (!rst_req && cause_q == CAUSE_USER)); // R9

endmodule

// File: rtl/wdk_top.sv
module wdk_top #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int DELAY_W   = 5,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              user_rst_i,
    input  logic              tick_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req_o,
    output logic              irq_o
);
    import wdk_pkg::*;

    localparam int CNT_W = (1 << DELAY_W) + 1;

    logic               sel_soft, sel_cfg, sel_arm, sel_commit;
    logic               wr_soft, wr_cfg, wr_k1, wr_k2, k1_ok, k2_ok;
    logic               cfg_en, cfg_clr, run, load, expire;
    logic [DELAY_W-1:0] cfg_delay;
    logic [CNT_W-1:0]   period;
    logic [2:0]         cause;

    always_comb begin
        sel_soft   = (bus_addr == ADDR_W'(OFS_SOFT));
        sel_cfg    = (bus_addr == ADDR_W'(OFS_CFG));
        sel_arm    = (bus_addr == ADDR_W'(OFS_ARM));
        sel_commit = (bus_addr == ADDR_W'(OFS_COMMIT));
        wr_soft    = bus_wr && sel_soft;
        wr_cfg     = bus_wr && sel_cfg;
        wr_k1      = bus_wr && sel_arm;
        wr_k2      = bus_wr && sel_commit;
        k1_ok      = (bus_wdata == DATA_W'(KEY_ARM));
        k2_ok      = (bus_wdata == DATA_W'(KEY_COMMIT));
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_cfg) begin
            bus_rdata[CFG_EN_BIT]    = cfg_en;
            bus_rdata[DELAY_W-1:0]   = cfg_delay;
        end else if (sel_arm) begin
            bus_rdata[2:0] = cause;
        end
    end

    wdk_cfg #(
        .DATA_W (DATA_W),
        .DELAY_W(DELAY_W),
        .CNT_W  (CNT_W)
    ) u_cfg (
        .clk   (clk),
        .por_n (por_n),
        .clr   (cfg_clr),
        .wr    (wr_cfg),
        .wdata (bus_wdata),
        .en    (cfg_en),
        .delay (cfg_delay),
        .period(period)
    );

    wdk_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk   (clk),
        .por_n (por_n),
        .load  (load),
        .run   (run),
        .tick  (tick_i),
        .period(period),
        .expire(expire)
    );

    wdk_fsm #(
        .PULSE_LEN(PULSE_LEN)
    ) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .user_rst_i(user_rst_i),
        .wr_soft   (wr_soft),
        .wr_k1     (wr_k1),
        .wr_k2     (wr_k2),
        .k1_ok     (k1_ok),
        .k2_ok     (k2_ok),
        .cfg_en    (cfg_en),
        .expire    (expire),
        .run       (run),
        .load      (load),
        .cfg_clr   (cfg_clr),
        .rst_req   (rst_req_o),
        .irq       (irq_o),
        .cause     (cause)
    );

    AST_EXPIRE_FIRES: assert property (@(posedge clk) disable iff (!por_n)
        (expire && !user_rst_i) |=> rst_req_o); // R3

    AST_IRQ_IN_PULSE: assert property (@(posedge clk) disable iff (!por_n)
        irq_o |-> rst_req_o); // R12

endmodule

// File: tb/wdk_top_bench.sv
module wdk_top_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        user_rst_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req_o, irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] K1 = 32'hABCD_1234;
    localparam logic [31:0] K2 = 32'h4321_DCBA;
    localparam logic [31:0] EN = 32'h8000_0000;

    always #2.5 clk = ~clk;

    wdk_top u_wdk_top (
        .clk(clk), .por_n(por_n), .user_rst_i(user_rst_i), .tick_i(tick_i),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req_o(rst_req_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic start(input logic [4:0] d);
        wr(4'h4, EN | 32'(d));
        step(1);
    endtask

    // rst_req_o must be high now; count pulse length and check irq and cause
    task automatic expect_pulse(input string tag, input logic [2:0] cause, input logic irq_exp);
        logic [31:0] v;
        int len = 0;
        check({tag, " rst_req raised"}, 32'(rst_req_o), 32'd1);
        check({tag, " irq"}, 32'(irq_o), 32'(irq_exp));
        while (rst_req_o && len < 40) begin
            len++;
            step(1);
        end
        check({tag, " R12 pulse length"}, 32'(len), 32'd16);
        rd(4'h8, v);
        check({tag, " R10 cause kept"}, v, 32'(cause));
        rd(4'h4, v);
        check({tag, " R10 cfg cleared"}, v, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 rst_req", 32'(rst_req_o), 32'd0);
        check("R1 irq", 32'(irq_o), 32'd0);
        rd(4'h8, v); check("R1 cause", v, 32'd0);
        rd(4'h4, v); check("R1 cfg", v, 32'd0);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        wr(4'h4, 32'h7FFF_FFFF);
        rd(4'h4, v); check("R2 cfg readback fields", v, 32'h0000_001F);
        wr(4'h4, 32'h0);
        rd(4'h4, v); check("R2 cfg cleared", v, 32'h0);
    endtask

    task automatic t_timeout();
        start(5'd1);
        ticks(3);
        check("R3 no fire before period", 32'(rst_req_o), 32'd0);
        ticks(1);
        expect_pulse("R3 timeout d=1", 3'd1, 1'b1);
        start(5'd4);
        ticks(31);
        check("R3 no fire at 31 of 32", 32'(rst_req_o), 32'd0);
        ticks(1);
        expect_pulse("R3 timeout d=4", 3'd1, 1'b1);
    endtask

    task automatic t_service();
        start(5'd1);
        ticks(3);
        wr(4'h8, K1);
        wr(4'hC, K2);
        check("R4 no fire after service", 32'(rst_req_o), 32'd0);
        ticks(3);
        check("R4 reloaded full period", 32'(rst_req_o), 32'd0);
        ticks(1);
        expect_pulse("R4 expiry after reload", 3'd1, 1'b1);
    endtask

    task automatic t_bad_value();
        start(5'd3);
        wr(4'h8, 32'h1234_5678);
        expect_pulse("R5 wrong arm key", 3'd2, 1'b0);
        start(5'd3);
        wr(4'h8, K1);
        check("R5 arm accepted", 32'(rst_req_o), 32'd0);
        wr(4'hC, K1);
        expect_pulse("R5 wrong commit key", 3'd2, 1'b0);
    endtask

    task automatic t_k2_first();
        wr(4'h0, 32'h0);
        expect_pulse("R8 soft reset", 3'd3, 1'b0);
        start(5'd3);
        wr(4'hC, K2);
        expect_pulse("R6 commit without arm", 3'd2, 1'b0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        start(5'd1);
        wr(4'h4, 32'h1);
        ticks(3);
        check("R7 still counting after disable", 32'(rst_req_o), 32'd0);
        ticks(1);
        expect_pulse("R7 disabled counter times out", 3'd1, 1'b1);
        start(5'd1);
        wr(4'h4, 32'h1);
        wr(4'h8, K1);
        wr(4'hC, K2);
        ticks(10);
        check("R7 stopped after key pair", 32'(rst_req_o), 32'd0);
        rd(4'h4, v); check("R7 enable clear", v, 32'h1);
    endtask

    task automatic t_user();
        logic [31:0] v;
        start(5'd2);
        ticks(2);
        user_rst_i = 1'b1;
        step(1);
        user_rst_i = 1'b0;
        check("R9 no reset request", 32'(rst_req_o), 32'd0);
        rd(4'h8, v); check("R9 cause user", v, 32'd4);
        rd(4'h4, v); check("R9 cfg cleared", v, 32'd0);
        ticks(10);
        check("R9 counter stopped", 32'(rst_req_o), 32'd0);
    endtask

    task automatic t_idle_keys();
        logic [31:0] v;
        wr(4'hC, K2);
        wr(4'h8, 32'hDEAD_BEEF);
        wr(4'hC, 32'h0);
        ticks(5);
        check("R11 idle keys ignored", 32'(rst_req_o), 32'd0);
        rd(4'h8, v); check("R11 cause unchanged", v, 32'd4);
    endtask

    task automatic t_por();
        logic [31:0] v;
        wr(4'h0, 32'h5);
        check("R8 soft reset from idle", 32'(rst_req_o), 32'd1);
        por_n = 1'b0;
        #1;
        check("R10 por drops request", 32'(rst_req_o), 32'd0);
        step(1);
        por_n = 1'b1;
        step(1);
        rd(4'h8, v); check("R10 por clears cause", v, 32'd0);
    endtask

    initial begin
        step(2);
        por_n = 1'b1;
        step(1);
        t_reset();
        t_cfg();
        t_timeout();
        t_service();
        t_bad_value();
        t_k2_first();
        t_stop();
        t_user();
        t_idle_keys();
        t_por();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got %0d expected completion", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule